// File: doc/BRIEF.md
# Banked Scratchpad Read Serializer

This block is an on-chip word scratchpad split into 32 banks, with a read port that takes one warp-wide request of up to 32 lanes. Each lane supplies a word address; the bank of a word is its address modulo 32. In each cycle every bank can deliver one row. Lanes that read the very same word share that delivery. Lanes that fall in the same bank but want different rows must wait for later passes. The serializer keeps issuing passes until every active lane has its word. It then raises a one-cycle completion pulse and reports how many passes the request needed.

A single-word write port fills the storage one word per cycle. The read side holds one request at a time. A new request is taken only while the serializer is idle, and `busy` stays high while passes remain. The controller is a three-state machine. IDLE accepts a request (transition IDLE to SERVE on a valid, non-empty request). SERVE performs one pass per cycle (SERVE to SERVE while lanes remain pending, SERVE to FINISH when the last pending lanes are served). FINISH presents the pulse and the pass count for one cycle (FINISH to IDLE, unconditionally).

Top module: `scr_serializer`

## Requirements
- R1: A write of `wr_data` to word `wr_addr` goes to bank `wr_addr[4:0]`, row `wr_addr[9:5]`. A later read of that word returns the written value.
- R2: A request whose active lanes all fall in distinct banks, such as stride 1 or stride 33, completes in exactly one pass.
- R3: Lanes reading the identical address are served together in one pass. A request where every lane reads one word takes one pass.
- R4: `pass_count` equals the largest number of distinct addresses any single bank receives. For example, stride 2 gives 2 and stride 32 gives 32.
- R5: In each pass, every bank serves the address of its lowest-numbered pending lane, together with all pending lanes that read that same address. `lane_served[i]` goes high in the cycle after lane i is served.
- R6: The read data of a lane is valid from the cycle after its pass. It holds its value through `rd_done` and until a later request serves that lane again.
- R7: `req_valid` is ignored while the block is not idle, and a request with an all-zero mask is ignored. Neither changes `pass_count`, `rd_data` or `busy`.
- R8: `busy` is high for exactly as many cycles as the request has passes. `rd_done` pulses for one cycle right after the last pass, and `req_ready` is high only when idle.
- R9: After reset, `busy`, `rd_done`, `lane_served` and `pass_count` are zero and `req_ready` is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one word this cycle |
| wr_addr | input | 10 | Word address of the write |
| wr_data | input | 32 | Write data |
| req_valid | input | 1 | Read request present |
| req_mask | input | 32 | Active lanes of the request |
| req_addr | input | 320 | Word address per lane, lane i in bits [10i+9:10i] |
| req_ready | output | 1 | Idle, a request can be taken |
| busy | output | 1 | Passes remain |
| rd_done | output | 1 | One-cycle completion pulse |
| lane_served | output | 32 | Lane has received its data |
| pass_count | output | 6 | Passes taken by the last request |
| rd_data | output | 1024 | Read data per lane, lane i in bits [32i+31:32i] |

## Verification
A fault in the pending-lane set or in the per-bank leader choice shows up at the ports within a cycle or two. `lane_served` shows the wrong lanes after the first pass, and `busy` stays high for the wrong number of cycles. A state machine stuck in SERVE keeps `busy` high and never pulses `rd_done`. A wrong bank index or row selection returns a wrong word on some lane at `rd_done`. A leak of a new request into a busy block changes `pass_count` or the held data of the request in flight.

// File: rtl/scr_pkg.sv
package scr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SERVE  = 2'd1,
        ST_FINISH = 2'd2
    } scr_state_e;
endpackage

// File: rtl/scr_bank.sv
module scr_bank #(
    parameter int ROW_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ROW_W-1:0]  wrow,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ROW_W-1:0]  rrow,
    output logic [DATA_W-1:0] rdata
);
    localparam int ROWS = 1 << ROW_W;

    logic [DATA_W-1:0] cells [ROWS];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[wrow] <= wdata;
        end
    end

    assign rdata = cells[rrow];
endmodule

// File: rtl/scr_arbiter.sv
module scr_arbiter #(
    parameter int LANES  = 32,
    parameter int BANKS  = 32,
    parameter int ADDR_W = 10
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [LANES-1:0]                  pend,
    input  logic [LANES-1:0][ADDR_W-1:0]      addr,
    output logic [LANES-1:0]                  grant,
    output logic [BANKS-1:0][ADDR_W-$clog2(BANKS)-1:0] row
);
    localparam int BANK_W = $clog2(BANKS);
    localparam int ROW_W  = ADDR_W - BANK_W;

    logic [BANKS-1:0]             lead_ok;
    logic [BANKS-1:0][ADDR_W-1:0] lead_addr;

    // Per bank: address of the lowest-numbered pending lane in that bank.
    always_comb begin
        for (int b = 0; b < BANKS; b++) begin
            lead_ok[b]   = 1'b0;
            lead_addr[b] = '0;
            for (int i = 0; i < LANES; i++) begin
                if (!lead_ok[b] && pend[i] &&
                    addr[i][BANK_W-1:0] == BANK_W'(b)) begin
                    lead_ok[b]   = 1'b1;
                    lead_addr[b] = addr[i];
                end
            end
        end
    end

    // A lane is served when it matches its bank leader's address.
    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign grant[g] = pend[g] &&
                (lead_addr[addr[g][BANK_W-1:0]] == addr[g]);
        end
        for (g = 0; g < BANKS; g++) begin : g_row
            assign row[g] = lead_addr[g][ADDR_W-1:BANK_W];
        end
    endgenerate

    // R5: any pending lane means at least one lane is served this pass
    a_r5_progress: assert property (@(posedge clk) disable iff (!rst_n)
        (pend != '0) |-> (grant != '0));

    // R5: only pending lanes can be served
    a_r5_grant_pending: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ~pend) == '0));

    logic unused_row_w;
    assign unused_row_w = (ROW_W > 0);
endmodule

// File: rtl/scr_serializer.sv
module scr_serializer #(
    parameter int LANES  = 32,
    parameter int BANKS  = 32,
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int CNT_W  = $clog2(LANES + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     req_valid,
    input  logic [LANES-1:0]         req_mask,
    input  logic [LANES*ADDR_W-1:0]  req_addr,
    output logic                     req_ready,
    output logic                     busy,
    output logic                     rd_done,
    output logic [LANES-1:0]         lane_served,
    output logic [CNT_W-1:0]         pass_count,
    output logic [LANES*DATA_W-1:0]  rd_data
);
    import scr_pkg::*;

    localparam int BANK_W = $clog2(BANKS);
    localparam int ROW_W  = ADDR_W - BANK_W;

    scr_state_e state_q, state_d;

    logic [LANES-1:0]              pend_q;
    logic [LANES-1:0]              served_q;
    logic [LANES-1:0][ADDR_W-1:0]  addr_q;
    logic [LANES-1:0][DATA_W-1:0]  data_q;
    logic [CNT_W-1:0]              cnt_q;

    logic [LANES-1:0]              grant;
    logic [BANKS-1:0][ROW_W-1:0]   bank_row;
    logic [BANKS-1:0][DATA_W-1:0]  bank_rdata;
    logic [LANES-1:0]              pend_left;
    logic                          accept;

    assign accept    = (state_q == ST_IDLE) && req_valid && (req_mask != '0);
    assign pend_left = pend_q & ~grant;

    // Storage banks; the write port selects one bank by the low address bits.
    genvar gb;
    generate
        for (gb = 0; gb < BANKS; gb++) begin : g_bank
            scr_bank #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_bank (
                .clk   (clk),
                .we    (wr_en && (wr_addr[BANK_W-1:0] == BANK_W'(gb))),
                .wrow  (wr_addr[ADDR_W-1:BANK_W]),
                .wdata (wr_data),
                .rrow  (bank_row[gb]),
                .rdata (bank_rdata[gb])
            );
        end
    endgenerate

    scr_arbiter #(.LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend_q),
        .addr  (addr_q),
        .grant (grant),
        .row   (bank_row)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_SERVE;
            ST_SERVE:  if (pend_left == '0) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs decoded from the state
    always_comb begin
        req_ready = 1'b0;
        busy      = 1'b0;
        rd_done   = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_SERVE:  busy      = 1'b1;
            ST_FINISH: rd_done   = 1'b1;
            default:   req_ready = 1'b0;
        endcase
    end

    // Request datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q   <= '0;
            served_q <= '0;
            addr_q   <= '0;
            data_q   <= '0;
            cnt_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        pend_q   <= req_mask;
                        served_q <= '0;
                        cnt_q    <= '0;
                        for (int i = 0; i < LANES; i++) begin
                            addr_q[i] <= req_addr[i*ADDR_W +: ADDR_W];
                        end
                    end
                end
                ST_SERVE: begin
                    pend_q   <= pend_left;
                    served_q <= served_q | grant;
                    cnt_q    <= cnt_q + 1'b1;
                    for (int i = 0; i < LANES; i++) begin
                        if (grant[i]) begin
                            data_q[i] <= bank_rdata[addr_q[i][BANK_W-1:0]];
                        end
                    end
                end
                ST_FINISH: begin
                    pend_q <= '0;
                end
                default: pend_q <= '0;
            endcase
        end
    end

    assign lane_served = served_q;
    assign pass_count  = cnt_q;

    generate
        for (gb = 0; gb < LANES; gb++) begin : g_out
            assign rd_data[gb*DATA_W +: DATA_W] = data_q[gb];
        end
    endgenerate

    // R8: busy and ready are never high together
    a_r8_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    // R8: the completion pulse lasts a single cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

    // R5: every pass shrinks the pending set
    a_r5_shrink: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SERVE) |=> ($countones(pend_q) < $past($countones(pend_q))));

    // R4: a finished request reports between 1 and LANES passes
    a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> (pass_count != '0 && pass_count <= CNT_W'(LANES)));

    // R6: results are held after completion
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> $stable(rd_data));

    // R7: addresses in flight are not overwritten while not idle
    a_r7_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(addr_q));
endmodule

// File: tb/sim_scr_serializer.sv
module sim_scr_serializer;
    localparam int LANES  = 32;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 6;
    localparam int WORDS  = 1 << ADDR_W;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    wr_en = 1'b0;
    logic [ADDR_W-1:0]       wr_addr = '0;
    logic [DATA_W-1:0]       wr_data = '0;
    logic                    req_valid = 1'b0;
    logic [LANES-1:0]        req_mask = '0;
    logic [LANES*ADDR_W-1:0] req_addr = '0;
    logic                    req_ready, busy, rd_done;
    logic [LANES-1:0]        lane_served;
    logic [CNT_W-1:0]        pass_count;
    logic [LANES*DATA_W-1:0] rd_data;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [DATA_W-1:0] shadow [WORDS];

    always #5 clk = ~clk;

    scr_serializer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .req_valid(req_valid), .req_mask(req_mask),
        .req_addr(req_addr), .req_ready(req_ready), .busy(busy),
        .rd_done(rd_done), .lane_served(lane_served),
        .pass_count(pass_count), .rd_data(rd_data)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic write_word(input int a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
        shadow[a] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [LANES*ADDR_W-1:0] stride_addr(input int base, input int stride);
        logic [LANES*ADDR_W-1:0] v;
        for (int i = 0; i < LANES; i++) begin
            v[i*ADDR_W +: ADDR_W] = ADDR_W'((base + i * stride) % WORDS);
        end
        return v;
    endfunction

    // Issue one request, count busy cycles, check count, data and flags.
    task automatic run_req(input string req, input logic [LANES-1:0] mask,
                           input logic [LANES*ADDR_W-1:0] addrs, input int exp_pass);
        int n;
        logic [LANES*DATA_W-1:0] snap;
        n = 0;
        @(negedge clk);
        req_valid = 1'b1; req_mask = mask; req_addr = addrs;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 64 && !rd_done; k++) begin
            if (busy) n++;
            @(negedge clk);
        end
        chk(rd_done == 1'b1, req, "done pulse", rd_done, 1);
        chk(n == exp_pass, "R8", {req, " busy cycles"}, n, exp_pass);
        chk(pass_count == CNT_W'(exp_pass), req, "pass_count", pass_count, exp_pass);
        chk(lane_served == mask, "R5", {req, " served flags"}, lane_served, mask);
        for (int i = 0; i < LANES; i++) begin
            if (mask[i]) begin
                int a;
                a = int'(addrs[i*ADDR_W +: ADDR_W]);
                chk(rd_data[i*DATA_W +: DATA_W] == shadow[a], "R1",
                    {req, " lane data"}, rd_data[i*DATA_W +: DATA_W], shadow[a]);
            end
        end
        snap = rd_data;
        @(negedge clk);
        chk(rd_done == 1'b0 && req_ready == 1'b1, "R8", "done one cycle", rd_done, 0);
        chk(rd_data == snap, "R6", "data held after done", rd_data[31:0], snap[31:0]);
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R9", "busy after reset", busy, 0);
        chk(req_ready == 1'b1, "R9", "ready after reset", req_ready, 1);
        chk(rd_done == 1'b0, "R9", "done after reset", rd_done, 0);
        chk(pass_count == '0, "R9", "count after reset", pass_count, 0);
        chk(lane_served == '0, "R9", "served after reset", lane_served, 0);
    endtask

    task automatic t_fill();
        for (int a = 0; a < WORDS; a++) begin
            write_word(a, 32'h5A00_0000 | DATA_W'(a * 65537));
        end
    endtask

    // R5: leader order within a bank, checked after the first pass
    task automatic t_order();
        logic [LANES*ADDR_W-1:0] v;
        v = '0;
        v[0*ADDR_W +: ADDR_W] = 10'd0;
        v[1*ADDR_W +: ADDR_W] = 10'd32;
        v[2*ADDR_W +: ADDR_W] = 10'd0;
        v[3*ADDR_W +: ADDR_W] = 10'd64;
        v[4*ADDR_W +: ADDR_W] = 10'd1;
        @(negedge clk);
        req_valid = 1'b1; req_mask = 32'h1F; req_addr = v;
        @(negedge clk);
        req_valid = 1'b0;
        chk(lane_served == '0 && busy, "R5", "nothing served before pass", lane_served, 0);
        @(negedge clk);
        chk(lane_served == 32'h15, "R5", "first pass lanes", lane_served, 32'h15);
        @(negedge clk);
        chk(lane_served == 32'h17, "R5", "second pass lanes", lane_served, 32'h17);
        @(negedge clk);
        chk(rd_done && pass_count == 6'd3, "R4", "three passes in bank 0", pass_count, 3);
        chk(rd_data[3*DATA_W +: DATA_W] == shadow[64], "R6", "lane 3 data",
            rd_data[3*DATA_W +: DATA_W], shadow[64]);
        @(negedge clk);
    endtask

    // R7: requests while busy and empty requests are ignored
    task automatic t_ignore();
        logic [LANES*DATA_W-1:0] snap;
        @(negedge clk);
        req_valid = 1'b1; req_mask = '1; req_addr = stride_addr(0, 32);
        @(negedge clk);
        req_mask = 32'h1; req_addr = stride_addr(5, 1);
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 64 && !rd_done; k++) @(negedge clk);
        chk(pass_count == 6'd32, "R7", "busy request ignored", pass_count, 32);
        chk(lane_served == '1, "R7", "served set of first request", lane_served, '1);
        chk(rd_data[DATA_W +: DATA_W] == shadow[32], "R7", "lane 1 data kept",
            rd_data[DATA_W +: DATA_W], shadow[32]);
        @(negedge clk);
        snap = rd_data;
        req_valid = 1'b1; req_mask = '0; req_addr = stride_addr(7, 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b0 && req_ready == 1'b1, "R7", "empty mask not taken", busy, 0);
        @(negedge clk);
        chk(pass_count == 6'd32 && rd_data == snap, "R7", "empty mask no change",
            pass_count, 32);
    endtask

    initial begin
        #1;
        t_reset();
        #20 rst_n = 1'b1;
        t_fill();
        run_req("R2", '1, stride_addr(0, 1), 1);
        run_req("R2", '1, stride_addr(3, 33), 1);
        run_req("R3", '1, stride_addr(77, 0), 1);
        run_req("R4", '1, stride_addr(0, 2), 2);
        run_req("R4", '1, stride_addr(4, 32), 32);
        run_req("R4", 32'h0000_FF00, stride_addr(10, 64), 8);
        write_word(100, 32'hDEAD_BEEF);
        run_req("R1", '1, stride_addr(100, 0), 1);
        t_order();
        t_ignore();
        summary();
    end
endmodule